// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Initialization Scheduler

This block handles refresh for an asynchronous DRAM whose refresh row address comes from a counter inside the device. After reset it waits out the mandatory power-up pause. It then runs a burst of CAS-before-RAS (CBR) refresh cycles to initialize the device, and after that it issues one CBR cycle per refresh interval. The block never drives a row address, because the device advances its own row counter on every CBR cycle.

The block does not own the memory pins. When a refresh is pending it raises `bus_req` to the access sequencer and waits for `bus_gnt`. Once granted, it drives its own strobe pattern on the `rf_*` outputs, and the controller multiplexes that pattern onto the device pins. The sequencer must hold the grant for as long as the request stays high. If intervals expire while the grant is withheld, they are counted up to a small cap. When the grant arrives, the counted refreshes are issued back to back.

`init_done` rises only after the initialization burst has finished. The sequencer uses it to hold off host accesses until then. All timing parameters are counted in clock cycles. At 100 MHz the defaults are a 200 µs pause, a 15.6 µs interval, a 30 ns precharge, a 10 ns CAS lead and a 50 ns RAS low time.

Two state machines control the block.

The mode machine has three states:
- PWR_WAIT: moves to INIT_BURST when the pause expires, which also loads the burst count.
- INIT_BURST: moves to RUN once no refresh is pending and the cycle sequencer is idle.
- RUN: terminal.

The cycle sequencer has six states:
- IDLE: moves to REQ when a refresh is pending.
- REQ: moves to PRECH on grant.
- PRECH: moves to CAS_LEAD after T_RP cycles.
- CAS_LEAD: moves to RAS_LOW after T_CSR cycles.
- RAS_LOW: moves to RECOVER after T_RAS cycles. Leaving RAS_LOW retires one pending refresh.
- RECOVER: after T_RP cycles it goes to CAS_LEAD if another refresh is pending and the grant is still held, otherwise to IDLE.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, the outputs are as follows. `bus_req` and `init_done` are 0. `rf_ras_n`, `rf_cas_n`, `rf_we_n` and `rf_oe_n` are 1. `rf_dq_oe` is 0.
- R2: `bus_req` first rises exactly PWR_WAIT_CYC+1 clock edges after reset is released. There is no strobe activity before that.
- R3: The initialization burst is INIT_CYCLES CBR cycles, issued back to back under a single `bus_req` assertion. `init_done` rises exactly PWR_WAIT_CYC+2+T_RP_CYC+INIT_CYCLES*(T_CSR_CYC+T_RAS_CYC+T_RP_CYC)+1 edges after reset release, with `bus_req` already low.
- R4: Every cycle is CAS-before-RAS. `rf_cas_n` falls while `rf_ras_n` is high, at least T_CSR_CYC cycles before `rf_ras_n` falls. `rf_cas_n` stays low through the whole RAS low time and rises in the same cycle as `rf_ras_n`.
- R5: `rf_ras_n` stays low for exactly T_RAS_CYC cycles. Before each `rf_cas_n` fall, `rf_ras_n` has been high for at least T_RP_CYC cycles.
- R6: `rf_we_n` and `rf_oe_n` are always 1, and `rf_dq_oe` is always 0. The data bus is never driven and no cycle looks like a write or test entry.
- R7: The strobes go low only while `bus_gnt` is high and `bus_req` is high. While the grant is withheld, `bus_req` stays high and no strobe moves.
- R8: After `init_done`, one refresh falls due every INTERVAL_CYC cycles. With an immediate grant, successive `rf_cas_n` falls are exactly INTERVAL_CYC cycles apart.
- R9: Intervals that expire while the grant is withheld are counted up to MAX_BACKLOG, and any further ones are dropped. When the grant is given, exactly the counted number of CBR cycles runs back to back, and then `bus_req` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_gnt | input | 1 | Bus grant from the access sequencer, held while `bus_req` is high |
| bus_req | output | 1 | Request for ownership of the DRAM pins |
| init_done | output | 1 | High once power-up initialization has finished |
| rf_ras_n | output | 1 | Row strobe pattern for the pin multiplexer, active low |
| rf_cas_n | output | 1 | Column strobe pattern for the pin multiplexer, active low |
| rf_we_n | output | 1 | Write enable pattern, held high |
| rf_oe_n | output | 1 | Output enable pattern, held high |
| rf_dq_oe | output | 1 | Data bus drive enable, held low (bus tri-stated) |

## Verification
The first grant pattern answers immediately. It fixes the exact power-up delay, the length of the initialization burst and the spacing between periodic refreshes, so an off-by-one in any counter shows up as a wrong cycle count.

The second pattern withholds the grant across a few intervals and releases it. Withholding across one interval yields a burst of two cycles. Withholding across four intervals yields a burst capped at the backlog limit. Together these separate correct counting from missing saturation and from dropped intervals.

A monitor watches every strobe edge in all phases and checks CAS-before-RAS order, the precharge and pulse widths, and the quiet write-enable, output-enable and data-bus lines. A second reset in mid-run checks that the whole initialization sequence restarts.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;

    typedef enum logic [1:0] {
        MODE_PWR_WAIT,
        MODE_INIT_BURST,
        MODE_RUN
    } mode_e;

    typedef enum logic [2:0] {
        CYC_IDLE,
        CYC_REQ,
        CYC_PRECH,
        CYC_CAS_LEAD,
        CYC_RAS_LOW,
        CYC_RECOVER
    } cyc_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rfs_pacer.sv
`timescale 1ns/1ps
module rfs_pacer #(
    parameter int unsigned PWR_WAIT_CYC = 20000,
    parameter int unsigned INTERVAL_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_en,
    input  logic run_en,
    output logic pwr_done,
    output logic tick
);
    import rfs_pkg::*;

    localparam int unsigned SPAN  = max2(PWR_WAIT_CYC, INTERVAL_CYC);
    localparam int unsigned CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] PWR_LAST = CNT_W'(PWR_WAIT_CYC - 1);
    localparam logic [CNT_W-1:0] INT_LAST = CNT_W'(INTERVAL_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             active;
    logic             at_last;

    always_comb begin
        active   = pwr_en | run_en;
        at_last  = pwr_en ? (cnt_q == PWR_LAST) : (cnt_q == INT_LAST);
        pwr_done = pwr_en & at_last;
        tick     = run_en & at_last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active || at_last) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/rfs_backlog.sv
`timescale 1ns/1ps
module rfs_backlog #(
    parameter int unsigned INIT_CYCLES = 8,
    parameter int unsigned MAX_BACKLOG = 4,
    localparam int unsigned PEND_W = $clog2(rfs_pkg::max2(INIT_CYCLES, MAX_BACKLOG) + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_init,
    input  logic              tick,
    input  logic              served,
    output logic [PEND_W-1:0] pend,
    output logic              pend_nz
);
    localparam logic [PEND_W-1:0] CAP    = PEND_W'(MAX_BACKLOG);
    localparam logic [PEND_W-1:0] INIT_V = PEND_W'(INIT_CYCLES);

    logic [PEND_W-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else if (load_init) begin
            pend_q <= INIT_V;
        end else begin
            unique case ({tick, served})
                2'b10: if (pend_q < CAP) pend_q <= pend_q + 1'b1;
                2'b01: if (pend_q != '0) pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    assign pend    = pend_q;
    assign pend_nz = (pend_q != '0);

endmodule

// File: rtl/rfs_cbr_seq.sv
`timescale 1ns/1ps
module rfs_cbr_seq #(
    parameter int unsigned T_RP_CYC  = 3,
    parameter int unsigned T_CSR_CYC = 1,
    parameter int unsigned T_RAS_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pend_nz,
    input  logic gnt,
    output logic req,
    output logic ras_n,
    output logic cas_n,
    output logic served,
    output logic idle
);
    import rfs_pkg::*;

    localparam int unsigned SPAN  = max2(max2(T_RP_CYC, T_CSR_CYC), T_RAS_CYC);
    localparam int unsigned CNT_W = $clog2(SPAN + 1);
    localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(T_RP_CYC - 1);
    localparam logic [CNT_W-1:0] CSR_LAST = CNT_W'(T_CSR_CYC - 1);
    localparam logic [CNT_W-1:0] RAS_LAST = CNT_W'(T_RAS_CYC - 1);

    cyc_e             state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             phase_end;
    logic             timed;

    always_comb begin
        timed     = 1'b0;
        phase_end = 1'b0;
        unique case (state_q)
            CYC_PRECH:    begin timed = 1'b1; phase_end = (cnt_q == RP_LAST);  end
            CYC_CAS_LEAD: begin timed = 1'b1; phase_end = (cnt_q == CSR_LAST); end
            CYC_RAS_LOW:  begin timed = 1'b1; phase_end = (cnt_q == RAS_LAST); end
            CYC_RECOVER:  begin timed = 1'b1; phase_end = (cnt_q == RP_LAST);  end
            default:      begin timed = 1'b0; phase_end = 1'b0;                end
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CYC_IDLE:     if (pend_nz)   state_d = CYC_REQ;
            CYC_REQ:      if (gnt)       state_d = CYC_PRECH;
            CYC_PRECH:    if (phase_end) state_d = CYC_CAS_LEAD;
            CYC_CAS_LEAD: if (phase_end) state_d = CYC_RAS_LOW;
            CYC_RAS_LOW:  if (phase_end) state_d = CYC_RECOVER;
            CYC_RECOVER:  if (phase_end) state_d = (pend_nz && gnt) ? CYC_CAS_LEAD : CYC_IDLE;
            default:                     state_d = CYC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q || !timed) cnt_q <= '0;
            else                              cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        req    = (state_q != CYC_IDLE);
        ras_n  = (state_q != CYC_RAS_LOW);
        cas_n  = !((state_q == CYC_CAS_LEAD) || (state_q == CYC_RAS_LOW));
        served = (state_q == CYC_RAS_LOW) && phase_end;
        idle   = (state_q == CYC_IDLE);
    end

    // R4: RAS falls only with CAS already low in the previous cycle
    a_r4_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && $past(!cas_n)));

    // R4: CAS releases together with RAS
    a_r4_rise_together: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n));

    // R7: strobes move only while the bus is requested
    a_r7_strobes_owned: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n || !cas_n) |-> req);

endmodule

// File: rtl/dram_refresh_sched.sv
`timescale 1ns/1ps
module dram_refresh_sched #(
    parameter int unsigned PWR_WAIT_CYC = 20000,
    parameter int unsigned INIT_CYCLES  = 8,
    parameter int unsigned INTERVAL_CYC = 1560,
    parameter int unsigned MAX_BACKLOG  = 4,
    parameter int unsigned T_RP_CYC     = 3,
    parameter int unsigned T_CSR_CYC    = 1,
    parameter int unsigned T_RAS_CYC    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_gnt,
    output logic bus_req,
    output logic init_done,
    output logic rf_ras_n,
    output logic rf_cas_n,
    output logic rf_we_n,
    output logic rf_oe_n,
    output logic rf_dq_oe
);
    import rfs_pkg::*;

    localparam int unsigned PEND_W = $clog2(max2(INIT_CYCLES, MAX_BACKLOG) + 1);
    localparam logic [PEND_W-1:0] CAP = PEND_W'(MAX_BACKLOG);

    mode_e             mode_q, mode_d;
    logic              pwr_en, run_en;
    logic              pwr_done, tick;
    logic              served, seq_idle, pend_nz;
    logic [PEND_W-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= MODE_PWR_WAIT;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_PWR_WAIT:   if (pwr_done)             mode_d = MODE_INIT_BURST;
            MODE_INIT_BURST: if (!pend_nz && seq_idle) mode_d = MODE_RUN;
            MODE_RUN:                                  mode_d = MODE_RUN;
            default:                                   mode_d = MODE_PWR_WAIT;
        endcase
    end

    always_comb begin
        pwr_en    = (mode_q == MODE_PWR_WAIT);
        run_en    = (mode_q == MODE_RUN);
        init_done = (mode_q == MODE_RUN);
        rf_we_n   = 1'b1;
        rf_oe_n   = 1'b1;
        rf_dq_oe  = 1'b0;
    end

    rfs_pacer #(
        .PWR_WAIT_CYC (PWR_WAIT_CYC),
        .INTERVAL_CYC (INTERVAL_CYC)
    ) pacer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_en   (pwr_en),
        .run_en   (run_en),
        .pwr_done (pwr_done),
        .tick     (tick)
    );

    rfs_backlog #(
        .INIT_CYCLES (INIT_CYCLES),
        .MAX_BACKLOG (MAX_BACKLOG)
    ) backlog_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_init (pwr_done),
        .tick      (tick),
        .served    (served),
        .pend      (pend),
        .pend_nz   (pend_nz)
    );

    rfs_cbr_seq #(
        .T_RP_CYC  (T_RP_CYC),
        .T_CSR_CYC (T_CSR_CYC),
        .T_RAS_CYC (T_RAS_CYC)
    ) seq_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_nz (pend_nz),
        .gnt     (bus_gnt),
        .req     (bus_req),
        .ras_n   (rf_ras_n),
        .cas_n   (rf_cas_n),
        .served  (served),
        .idle    (seq_idle)
    );

    // R2: nothing is requested or strobed during the power-up pause
    a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PWR_WAIT) |-> (!bus_req && rf_ras_n && rf_cas_n));

    // R3: ready only once the burst is fully retired and the bus released
    a_r3_done_clean: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (!bus_req && pend == '0));

    // R9: in normal running the pending count never exceeds the cap
    a_r9_backlog_cap: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pend <= CAP));

endmodule

// File: tb/dram_refresh_sched_tb_top.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb_top;

    localparam int PWR   = 20;
    localparam int NINIT = 8;
    localparam int INTV  = 40;
    localparam int BKLG  = 3;
    localparam int TRP   = 3;
    localparam int TCSR  = 1;
    localparam int TRAS  = 5;
    localparam int INIT_DONE_EDGE = PWR + 2 + TRP + NINIT * (TCSR + TRAS + TRP) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_gnt = 1'b0;
    logic block_gnt = 1'b0;
    logic bus_req, init_done, rf_ras_n, rf_cas_n, rf_we_n, rf_oe_n, rf_dq_oe;

    int n_chk = 0;
    int n_bad = 0;
    time t_rel = 0;

    int  cbr_cnt = 0, req_rise = 0;
    int  v_order = 0, v_pre = 0, v_raslen = 0, v_gnt = 0, v_pins = 0;
    time fall_prev = 0, fall_last = 0;

    always #5 clk = ~clk;

    dram_refresh_sched #(
        .PWR_WAIT_CYC (PWR),
        .INIT_CYCLES  (NINIT),
        .INTERVAL_CYC (INTV),
        .MAX_BACKLOG  (BKLG),
        .T_RP_CYC     (TRP),
        .T_CSR_CYC    (TCSR),
        .T_RAS_CYC    (TRAS)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_gnt   (bus_gnt),
        .bus_req   (bus_req),
        .init_done (init_done),
        .rf_ras_n  (rf_ras_n),
        .rf_cas_n  (rf_cas_n),
        .rf_we_n   (rf_we_n),
        .rf_oe_n   (rf_oe_n),
        .rf_dq_oe  (rf_dq_oe)
    );

    // grant responder: follows the request unless blocked
    initial forever begin
        @(negedge clk);
        #1;
        bus_gnt = bus_req && !block_gnt;
    end

    // strobe monitor
    initial begin
        int  ras_hi = 0, ras_lo = 0, cas_lo = 0;
        logic p_ras = 1'b1, p_cas = 1'b1, p_req = 1'b0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                ras_hi = 1000; ras_lo = 0; cas_lo = 0;
                p_ras = 1'b1; p_cas = 1'b1; p_req = 1'b0;
            end else begin
                if (p_cas && !rf_cas_n) begin
                    cbr_cnt++;
                    fall_prev = fall_last;
                    fall_last = $time;
                    if (!rf_ras_n) v_order++;
                    if (ras_hi < TRP) v_pre++;
                end
                if (p_ras && !rf_ras_n && (rf_cas_n || cas_lo < TCSR)) v_order++;
                if (!p_ras && rf_ras_n && ras_lo != TRAS) v_raslen++;
                if (!p_cas && rf_cas_n && !(rf_ras_n && !p_ras)) v_order++;
                if ((!rf_ras_n || !rf_cas_n) && !(bus_gnt && bus_req)) v_gnt++;
                if (!rf_we_n || !rf_oe_n || rf_dq_oe) v_pins++;
                if (!p_req && bus_req) req_rise++;
                ras_hi = rf_ras_n ? ((ras_hi < 1000) ? ras_hi + 1 : ras_hi) : 0;
                ras_lo = rf_ras_n ? 0 : ras_lo + 1;
                cas_lo = rf_cas_n ? 0 : cas_lo + 1;
                p_ras = rf_ras_n; p_cas = rf_cas_n; p_req = bus_req;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int edges_since_rel();
        return int'(($time - t_rel) / 10);
    endfunction

    // R1: reset values, then release at a falling edge
    task automatic t_reset();
        rst_n = 1'b0;
        block_gnt = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 outputs in reset", {bus_req, init_done, rf_ras_n, rf_cas_n, rf_we_n, rf_oe_n, rf_dq_oe}, 7'b0011110);
        rst_n = 1'b1;
        t_rel = $time;
        @(negedge clk);
        chk("R1 outputs after release", {bus_req, init_done, rf_ras_n, rf_cas_n, rf_we_n, rf_oe_n, rf_dq_oe}, 7'b0011110);
    endtask

    // R2: the pause length before the first request
    task automatic t_powerup();
        int c0 = cbr_cnt;
        for (int i = 0; i < 1000 && !bus_req; i++) @(negedge clk);
        chk("R2 edges to first request", edges_since_rel(), PWR + 1);
        chk("R2 no strobe during pause", cbr_cnt - c0, 0);
        chk("R2 init_done low at request", init_done, 0);
    endtask

    // R3: burst count, single request, exact ready edge
    task automatic t_init_burst();
        int c0 = cbr_cnt;
        int r0 = req_rise;
        for (int i = 0; i < 2000 && !init_done; i++) @(negedge clk);
        chk("R3 edges to init_done", edges_since_rel(), INIT_DONE_EDGE);
        chk("R3 burst cycle count", cbr_cnt - c0, NINIT);
        chk("R3 burst under one request", req_rise - r0, 0);
        chk("R3 bus released at ready", bus_req, 0);
    endtask

    // R8: even spacing with immediate grant
    task automatic t_periodic();
        int c0;
        for (int k = 0; k < 3; k++) begin
            int c1 = cbr_cnt;
            for (int i = 0; i < 1000 && cbr_cnt == c1; i++) @(negedge clk);
        end
        chk("R8 spacing A", int'((fall_last - fall_prev) / 10), INTV);
        c0 = cbr_cnt;
        for (int i = 0; i < 1000 && cbr_cnt == c0; i++) @(negedge clk);
        chk("R8 spacing B", int'((fall_last - fall_prev) / 10), INTV);
        c0 = cbr_cnt;
        repeat (10 * INTV) @(negedge clk);
        chk("R8 cycles in ten intervals", cbr_cnt - c0, 10);
    endtask

    // R7 and R9: withhold the grant, then release
    task automatic t_backlog(input int hold, input int exp_burst);
        int c0;
        for (int i = 0; i < 1000 && bus_req; i++) @(negedge clk);
        block_gnt = 1'b1;
        for (int i = 0; i < 1000 && !bus_req; i++) @(negedge clk);
        c0 = cbr_cnt;
        repeat (hold) @(negedge clk);
        chk("R7 no strobe while withheld", cbr_cnt - c0, 0);
        chk("R7 request held while withheld", bus_req, 1);
        block_gnt = 1'b0;
        c0 = cbr_cnt;
        for (int i = 0; i < 1000 && bus_req; i++) @(negedge clk);
        chk("R9 burst after release", cbr_cnt - c0, exp_burst);
    endtask

    // R4 R5 R6 R7: accumulated monitor findings
    task automatic t_protocol();
        chk("R4 CBR ordering violations", v_order, 0);
        chk("R5 precharge violations", v_pre, 0);
        chk("R5 RAS width violations", v_raslen, 0);
        chk("R6 WE/OE/data drive violations", v_pins, 0);
        chk("R7 strobe without grant", v_gnt, 0);
    endtask

    initial begin
        #(10 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_powerup();
        t_init_burst();
        t_periodic();
        t_backlog(45, 2);
        t_backlog(165, BKLG);
        t_periodic();
        repeat (17) @(negedge clk);
        t_reset();
        t_powerup();
        t_init_burst();
        t_protocol();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule